// File: doc/BRIEF.md
# Bridge Write Termination Response Controller

This block sits in the forwarding path of a bus bridge. It decides what happens after the target of a forwarded write has ended the transaction. Each cycle with `term_valid` high presents one termination. The inputs say whether the write was delayed or posted and how the target ended it. From these the block produces, one cycle later, the response owed to the originating initiator, a request to re-issue the write toward the target, pulses that set status bits, and a system-error pulse.

Delayed writes keep their result for the initiator and are retried until data moves, an abort arrives, or a retry budget runs out. The budget is 2^SHORT_LOG2 attempts by default. A configuration input raises it to 2^LONG_LOG2. When the budget is used up, the write is discarded. A system error may then be signalled, subject to an enable bit and a separate disable bit for this one event. Posted writes have already completed toward the initiator, so only local actions follow for them.

Top module: `wr_term_resp`

## Requirements
- R1: After reset, all outputs are low and the retry count is zero.
- R2: The termination code is 0 normal, 1 retry, 2 disconnect, 3 master abort, 4 target abort. Outputs are registered single-cycle pulses that appear in the cycle after `term_valid`. A cycle with `term_valid` low, or with code 5, 6 or 7, produces no output and leaves the count unchanged.
- R3: A delayed write ending in normal or disconnect gives `resp_valid` with code 2 (disconnect) when `multi_phase` is set, and code 0 (done) otherwise. It clears the retry count.
- R4: A delayed write ending in retry below the limit gives response code 1 (retry) and `reissue`, and it increments the retry count.
- R5: A delayed master abort gives response code 3 and `rcv_ma_set`. A delayed target abort gives response code 4 together with `rcv_ta_set` and `sig_ta_set`. Both clear the count.
- R6: A posted write never gives `resp_valid`. A posted normal gives nothing. A posted retry or disconnect gives `reissue`.
- R7: A posted master abort gives only `rcv_ma_set`. A posted target abort gives only `rcv_ta_set`.
- R8: The delayed retry that brings the count to 2^SHORT_LOG2, or to 2^LONG_LOG2 when `long_limit` is high, gives `discard` instead of a response or a re-issue, and it clears the count.
- R9: `serr` pulses together with `discard` only when `serr_en` is 1 and `nd_dis` is 0.
- R10: `new_dw` clears the count. A termination in the same cycle counts from zero. Posted terminations do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| term_valid | input | 1 | A termination is presented this cycle |
| is_posted | input | 1 | 1 posted write, 0 delayed write |
| term_code | input | 3 | Target termination code |
| multi_phase | input | 1 | Initiator requested more than one data phase |
| new_dw | input | 1 | A new delayed write was accepted |
| serr_en | input | 1 | System-error enable |
| nd_dis | input | 1 | Disables system error for a delayed write that was never delivered |
| long_limit | input | 1 | Selects the long retry budget |
| resp_valid | output | 1 | Response to initiator is valid |
| resp_code | output | 3 | 0 done, 1 retry, 2 disconnect, 3 master abort, 4 target abort |
| reissue | output | 1 | Re-issue the write toward the target |
| discard | output | 1 | Delayed write dropped at the retry limit |
| rcv_ta_set | output | 1 | Set received-target-abort status |
| sig_ta_set | output | 1 | Set signaled-target-abort status |
| rcv_ma_set | output | 1 | Set received-master-abort status |
| serr | output | 1 | System-error pulse |

## Verification
The hardest case to reach is the retry limit. The real budgets are millions of attempts, so the bench builds the block with budgets of 8 and 16. It then walks long unbroken chains of delayed retries up to and past the boundary. Other chains are broken by a normal termination, by `new_dw`, by `new_dw` arriving in the same cycle as a retry, and by interleaved posted retries. Each break shows whether the count was cleared or left alone. The error gating is checked with each combination of enable and disable at the limit.

// File: rtl/wr_term_resp.sv
module wr_term_resp #(
  parameter int SHORT_LOG2 = 24,
  parameter int LONG_LOG2  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       term_valid,
  input  logic       is_posted,
  input  logic [2:0] term_code,
  input  logic       multi_phase,
  input  logic       new_dw,
  input  logic       serr_en,
  input  logic       nd_dis,
  input  logic       long_limit,
  output logic       resp_valid,
  output logic [2:0] resp_code,
  output logic       reissue,
  output logic       discard,
  output logic       rcv_ta_set,
  output logic       sig_ta_set,
  output logic       rcv_ma_set,
  output logic       serr
);
  localparam int CW = LONG_LOG2 + 1;

  logic [CW-1:0] cnt, cnt_base, cnt_inc, limit;
  logic dly, pst, hit;

  assign cnt_base = new_dw ? '0 : cnt;
  assign cnt_inc  = cnt_base + CW'(1);
  assign limit    = long_limit ? (CW'(1) << LONG_LOG2) : (CW'(1) << SHORT_LOG2);
  assign dly      = term_valid && !is_posted;
  assign pst      = term_valid && is_posted;
  assign hit      = dly && term_code == 3'd1 && cnt_inc == limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      resp_valid <= 1'b0;
      resp_code  <= 3'd0;
      reissue    <= 1'b0;
      discard    <= 1'b0;
      rcv_ta_set <= 1'b0;
      sig_ta_set <= 1'b0;
      rcv_ma_set <= 1'b0;
      serr       <= 1'b0;
    end else begin
      cnt        <= cnt_base;
      resp_valid <= 1'b0;
      resp_code  <= 3'd0;
      reissue    <= 1'b0;
      discard    <= 1'b0;
      rcv_ta_set <= 1'b0;
      sig_ta_set <= 1'b0;
      rcv_ma_set <= 1'b0;
      serr       <= 1'b0;
      if (dly) begin
        case (term_code)
          3'd0, 3'd2: begin
            cnt        <= '0;
            resp_valid <= 1'b1;
            resp_code  <= multi_phase ? 3'd2 : 3'd0;
          end
          3'd1: begin
            if (hit) begin
              cnt     <= '0;
              discard <= 1'b1;
              serr    <= serr_en && !nd_dis;
            end else begin
              cnt        <= cnt_inc;
              resp_valid <= 1'b1;
              resp_code  <= 3'd1;
              reissue    <= 1'b1;
            end
          end
          3'd3: begin
            cnt        <= '0;
            resp_valid <= 1'b1;
            resp_code  <= 3'd3;
            rcv_ma_set <= 1'b1;
          end
          3'd4: begin
            cnt        <= '0;
            resp_valid <= 1'b1;
            resp_code  <= 3'd4;
            rcv_ta_set <= 1'b1;
            sig_ta_set <= 1'b1;
          end
          default: ;
        endcase
      end else if (pst) begin
        case (term_code)
          3'd1, 3'd2: reissue    <= 1'b1;
          3'd3:       rcv_ma_set <= 1'b1;
          3'd4:       rcv_ta_set <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wr_term_resp_chk.sv
module wr_term_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       term_valid,
  input logic       is_posted,
  input logic [2:0] term_code,
  input logic       serr_en,
  input logic       nd_dis,
  input logic       resp_valid,
  input logic       reissue,
  input logic       discard,
  input logic       rcv_ta_set,
  input logic       sig_ta_set,
  input logic       serr
);
  assert_serr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> discard && $past(serr_en && !nd_dis));

  assert_no_posted_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(term_valid && !is_posted));

  assert_discard_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> !reissue && !resp_valid && $past(term_valid && !is_posted && term_code == 3'd1));

  assert_sig_ta_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sig_ta_set |-> rcv_ta_set && resp_valid);

  assert_reissue_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reissue |-> $past(term_valid && (term_code == 3'd1 || term_code == 3'd2)));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !term_valid |=> !resp_valid && !reissue && !discard && !serr);
endmodule

bind wr_term_resp wr_term_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .term_valid(term_valid), .is_posted(is_posted),
  .term_code(term_code), .serr_en(serr_en), .nd_dis(nd_dis),
  .resp_valid(resp_valid), .reissue(reissue), .discard(discard),
  .rcv_ta_set(rcv_ta_set), .sig_ta_set(sig_ta_set), .serr(serr)
);

// File: tb/tb_wr_term_resp.sv
module tb_wr_term_resp;
  localparam int SL = 3, LL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic term_valid = 0, is_posted = 0, multi_phase = 0, new_dw = 0;
  logic serr_en = 1, nd_dis = 0, long_limit = 0;
  logic [2:0] term_code = 0;
  logic resp_valid, reissue, discard, rcv_ta_set, sig_ta_set, rcv_ma_set, serr;
  logic [2:0] resp_code;

  always #2 clk = ~clk;

  wr_term_resp #(.SHORT_LOG2(SL), .LONG_LOG2(LL)) dut (
    .clk(clk), .rst_n(rst_n), .term_valid(term_valid), .is_posted(is_posted),
    .term_code(term_code), .multi_phase(multi_phase), .new_dw(new_dw),
    .serr_en(serr_en), .nd_dis(nd_dis), .long_limit(long_limit),
    .resp_valid(resp_valid), .resp_code(resp_code), .reissue(reissue),
    .discard(discard), .rcv_ta_set(rcv_ta_set), .sig_ta_set(sig_ta_set),
    .rcv_ma_set(rcv_ma_set), .serr(serr));

  typedef struct {
    logic [9:0] exp;
    int         stamp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0, cyc = 0, mcnt = 0;
  bit mon_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [9:0] outs();
    return {resp_valid, resp_code, reissue, discard, rcv_ta_set, sig_ta_set, rcv_ma_set, serr};
  endfunction

  always @(negedge clk) begin
    if (mon_on && q.size() > 0 && q[0].stamp < cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (outs() !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b", it.tag, outs(), it.exp);
      end
    end
  end

  task automatic drive(input bit tv, input bit p, input int code, input bit mp, input bit nd, input string tag);
    logic rv, ri, dc, rta, sta, rma, se;
    logic [2:0] rc;
    int base, lim;
    item_t it;
    term_valid = tv; is_posted = p; term_code = 3'(code); multi_phase = mp; new_dw = nd;
    rv = 0; rc = 0; ri = 0; dc = 0; rta = 0; sta = 0; rma = 0; se = 0;
    base = nd ? 0 : mcnt;
    mcnt = base;
    lim = long_limit ? (1 << LL) : (1 << SL);
    if (tv && !p) begin
      case (code)
        0, 2: begin rv = 1; rc = mp ? 3'd2 : 3'd0; mcnt = 0; end
        1: if (base + 1 == lim) begin dc = 1; se = serr_en && !nd_dis; mcnt = 0; end
           else begin rv = 1; rc = 3'd1; ri = 1; mcnt = base + 1; end
        3: begin rv = 1; rc = 3'd3; rma = 1; mcnt = 0; end
        4: begin rv = 1; rc = 3'd4; rta = 1; sta = 1; mcnt = 0; end
        default: ;
      endcase
    end else if (tv && p) begin
      case (code)
        1, 2: ri = 1;
        3: rma = 1;
        4: rta = 1;
        default: ;
      endcase
    end
    it.exp = {rv, rc, ri, dc, rta, sta, rma, se};
    it.stamp = cyc;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, "R2 idle");
  endtask

  task automatic retries(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1, 0, 1, 0, 0, tag);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outs() !== 10'd0) begin
      failures++;
      $display("FAIL R1 reset actual=%b expected=%b", outs(), 10'd0);
    end
    rst_n = 1;
    mon_on = 1;
    idle(2);
    // R3 delayed normal and disconnect
    drive(1, 0, 0, 0, 0, "R3 dly normal single");
    drive(1, 0, 0, 1, 0, "R3 dly normal multi");
    drive(1, 0, 2, 1, 0, "R3 dly disc multi");
    drive(1, 0, 2, 0, 0, "R3 dly disc single");
    // R4 delayed retry
    drive(1, 0, 1, 0, 1, "R4 dly retry");
    // R5 aborts
    drive(1, 0, 3, 0, 0, "R5 dly master abort");
    drive(1, 0, 4, 1, 0, "R5 dly target abort");
    // R6/R7 posted
    drive(1, 1, 0, 1, 0, "R6 pst normal");
    drive(1, 1, 1, 0, 0, "R6 pst retry");
    drive(1, 1, 2, 1, 0, "R6 pst disc");
    drive(1, 1, 3, 0, 0, "R7 pst master abort");
    drive(1, 1, 4, 0, 0, "R7 pst target abort");
    // R2 reserved codes
    for (int c = 5; c < 8; c++) drive(1, c[0], c, 1, 0, "R2 reserved code");
    idle(1);
    // R8/R9 short limit, serr enabled; R1 count starts at zero
    drive(1, 0, 1, 0, 1, "R10 new_dw with retry");
    retries(6, "R4 retry chain");
    drive(1, 0, 1, 0, 0, "R8 R9 limit short serr");
    retries(7, "R8 count cleared after limit");
    serr_en = 0;
    drive(1, 0, 1, 0, 0, "R9 serr disabled");
    serr_en = 1; nd_dis = 1;
    retries(7, "R4 chain");
    drive(1, 0, 1, 0, 0, "R9 nd_dis set");
    nd_dis = 0;
    // R10 clear by normal termination
    retries(5, "R4 chain");
    drive(1, 0, 0, 0, 0, "R10 clear by normal");
    retries(7, "R10 after clear");
    drive(1, 0, 1, 0, 0, "R8 limit after clear");
    // R10 new_dw alone clears
    retries(5, "R4 chain");
    drive(0, 0, 0, 0, 1, "R10 new_dw alone");
    retries(7, "R10 after new_dw");
    drive(1, 0, 1, 0, 0, "R8 limit after new_dw");
    // R10 posted does not touch count
    retries(4, "R4 chain");
    drive(1, 1, 1, 0, 0, "R10 pst retry interleave");
    drive(1, 1, 4, 0, 0, "R10 pst abort interleave");
    retries(3, "R10 continue");
    drive(1, 0, 1, 0, 0, "R10 R8 limit with interleave");
    // R8 long limit
    long_limit = 1;
    retries(15, "R8 long chain");
    drive(1, 0, 1, 0, 0, "R8 long limit");
    long_limit = 0;
    idle(3);
    while (q.size() > 0) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule